// File: doc/BRIEF.md
# Multiprocessor Serial Node Address Filter

This block decides whether an address frame on a nine-bit serial link selects the local node. Software programs two 8-bit registers: a node address and a care mask. When the receiver reports a completed frame whose ninth bit is set, and multiprocessor operation is enabled, the frame byte is checked against two patterns. The first is the node address, restricted to the positions the mask marks as cared. The second is a broadcast pattern, formed at run time as the bitwise OR of the two registers. A hit on either pattern selects the node.

The select result is registered on the edge that closes the address frame. It then holds through the data frames that follow, until the next address frame replaces it. The receive path uses the select output to decide whether to keep those data frames. With multiprocessor operation disabled, the output is held active so every frame is accepted. Both registers clear to 00h. After reset, both patterns are therefore entirely don't-care and any address is accepted.

Top module: `node_addr_filter`

## Requirements
- R1: After reset both registers hold 00h and `sel_o` is 1. In this state every address byte is accepted.
- R2: A cycle with `cfg_we_addr` high loads `cfg_wdata` into the node address register. The new value is used by compares from the following cycle on.
- R3: A cycle with `cfg_we_mask` high loads `cfg_wdata` into the care mask register. The new value is used by compares from the following cycle on.
- R4: The node-address compare ignores every bit where the mask is 0 and requires equality at every bit where the mask is 1. For example, with address A4h and mask FAh, byte A0h hits and byte A3h misses.
- R5: The broadcast pattern is address OR mask. A byte hits it when it has a 1 wherever the pattern has a 1; zero positions of the pattern are don't-care. A pattern of FFh is hit only by FFh.
- R6: The node is selected when either the node-address compare or the broadcast compare hits.
- R7: A frame counts as an address frame only in a cycle with `frm_done`=1, `frm_bit9`=1 and `mp_en`=1. Its result appears on `sel_o` from the next cycle.
- R8: While `mp_en` is 1, data frames (`frm_bit9`=0) and idle cycles leave `sel_o` unchanged.
- R9: While `mp_en` is 0, `sel_o` is 1 and frames do not alter the stored result. When `mp_en` returns to 1, `sel_o` again shows the last stored result.
- R10: When a register write and an address frame fall in the same cycle, the frame is compared against the register contents from before the write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we_addr | input | 1 | Write strobe for the node address register |
| cfg_we_mask | input | 1 | Write strobe for the care mask register |
| cfg_wdata | input | W | Register write data |
| mp_en | input | 1 | Multiprocessor address filtering enable |
| frm_done | input | 1 | One-cycle strobe: a received frame is complete |
| frm_bit9 | input | 1 | Ninth bit of the completed frame (1 = address frame) |
| frm_byte | input | W | Eight data bits of the completed frame |
| sel_o | output | 1 | Node selected; gates reception of following data frames |

## Verification
A configuration write and an address-frame compare can fall on the same clock edge. The bench provokes this by holding a mask write strobe in the very cycle that `frm_done` is raised for an address byte. The first result must follow the old mask; a second frame with the same byte must then follow the new mask. The chosen byte misses under the old contents and hits under the new ones, so a design that bypasses the write data into the compare shows up as a wrong select value.

// File: rtl/nodeaddr_pkg.sv
package nodeaddr_pkg;
  localparam int NA_W = 8;

  // One bit of the node-address compare: cared bits must equal.
  function automatic logic bit_given_ok(input logic b, input logic a, input logic m);
    return ~m | ~(b ^ a);
  endfunction

  // One bit of the broadcast compare: a 1 in the pattern needs a 1 in the byte.
  function automatic logic bit_bcast_ok(input logic b, input logic p);
    return ~p | b;
  endfunction
endpackage

// File: rtl/node_cfg_regs.sv
module node_cfg_regs #(
  parameter int W = nodeaddr_pkg::NA_W
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         we_addr,
  input  logic         we_mask,
  input  logic [W-1:0] wdata,
  output logic [W-1:0] addr_q,
  output logic [W-1:0] mask_q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q <= '0;
      mask_q <= '0;
    end else begin
      if (we_addr) addr_q <= wdata;
      if (we_mask) mask_q <= wdata;
    end
  end
endmodule

// File: rtl/node_pattern_cmp.sv
module node_pattern_cmp #(
  parameter int W = nodeaddr_pkg::NA_W
) (
  input  logic [W-1:0] byte_i,
  input  logic [W-1:0] addr_i,
  input  logic [W-1:0] mask_i,
  output logic         given_hit,
  output logic         bcast_hit
);
  import nodeaddr_pkg::*;

  logic [W-1:0] bcast_pat;
  logic [W-1:0] given_ok;
  logic [W-1:0] bcast_ok;

  assign bcast_pat = addr_i | mask_i;

  for (genvar i = 0; i < W; i++) begin : g_bit
    assign given_ok[i] = bit_given_ok(byte_i[i], addr_i[i], mask_i[i]);
    assign bcast_ok[i] = bit_bcast_ok(byte_i[i], bcast_pat[i]);
  end

  assign given_hit = &given_ok;
  assign bcast_hit = &bcast_ok;
endmodule

// File: rtl/node_sel_reg.sv
module node_sel_reg (
  input  logic clk,
  input  logic rst_n,
  input  logic upd,
  input  logic hit,
  output logic sel_q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   sel_q <= 1'b1;
    else if (upd) sel_q <= hit;
  end
endmodule

// File: rtl/node_addr_filter.sv
module node_addr_filter #(
  parameter int W = nodeaddr_pkg::NA_W
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         cfg_we_addr,
  input  logic         cfg_we_mask,
  input  logic [W-1:0] cfg_wdata,
  input  logic         mp_en,
  input  logic         frm_done,
  input  logic         frm_bit9,
  input  logic [W-1:0] frm_byte,
  output logic         sel_o
);
  logic [W-1:0] addr_q;
  logic [W-1:0] mask_q;
  logic         given_hit;
  logic         bcast_hit;
  logic         hit_any;
  logic         upd_evt;
  logic         sel_q;

  node_cfg_regs #(.W(W)) u_regs (
    .clk     (clk),
    .rst_n   (rst_n),
    .we_addr (cfg_we_addr),
    .we_mask (cfg_we_mask),
    .wdata   (cfg_wdata),
    .addr_q  (addr_q),
    .mask_q  (mask_q)
  );

  node_pattern_cmp #(.W(W)) u_cmp (
    .byte_i    (frm_byte),
    .addr_i    (addr_q),
    .mask_i    (mask_q),
    .given_hit (given_hit),
    .bcast_hit (bcast_hit)
  );

  assign hit_any = given_hit | bcast_hit;
  assign upd_evt = frm_done & frm_bit9 & mp_en;

  node_sel_reg u_sel (
    .clk   (clk),
    .rst_n (rst_n),
    .upd   (upd_evt),
    .hit   (hit_any),
    .sel_q (sel_q)
  );

  assign sel_o = ~mp_en | sel_q;
endmodule

// File: rtl/node_addr_filter_chk.sv
module node_addr_filter_chk #(
  parameter int W = 8
) (
  input logic         clk,
  input logic         rst_n,
  input logic         cfg_we_addr,
  input logic         cfg_we_mask,
  input logic [W-1:0] cfg_wdata,
  input logic         mp_en,
  input logic [W-1:0] frm_byte,
  input logic         sel_o,
  input logic [W-1:0] addr_q,
  input logic [W-1:0] mask_q,
  input logic         hit_any,
  input logic         upd_evt,
  input logic         sel_q
);
  AST_RESET_OPEN: assert property (@(posedge clk) disable iff (!rst_n)
    (addr_q == '0 && mask_q == '0) |-> hit_any);                         // R1
  AST_ADDR_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_we_addr |=> addr_q == $past(cfg_wdata));                          // R2
  AST_MASK_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_we_mask |=> mask_q == $past(cfg_wdata));                          // R3
  AST_BCAST_FULL: assert property (@(posedge clk) disable iff (!rst_n)
    ((addr_q | mask_q) == '1 && frm_byte == '1) |-> hit_any);             // R5
  AST_RESULT_TAKEN: assert property (@(posedge clk) disable iff (!rst_n)
    upd_evt |=> sel_q == $past(hit_any));                                 // R7
  AST_RESULT_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    !upd_evt |=> $stable(sel_q));                                         // R8
  AST_PASS_THRU: assert property (@(posedge clk) disable iff (!rst_n)
    !mp_en |-> sel_o);                                                    // R9
endmodule

bind node_addr_filter node_addr_filter_chk #(.W(W)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .cfg_we_addr (cfg_we_addr),
  .cfg_we_mask (cfg_we_mask),
  .cfg_wdata   (cfg_wdata),
  .mp_en       (mp_en),
  .frm_byte    (frm_byte),
  .sel_o       (sel_o),
  .addr_q      (addr_q),
  .mask_q      (mask_q),
  .hit_any     (hit_any),
  .upd_evt     (upd_evt),
  .sel_q       (sel_q)
);

// File: tb/node_addr_filter_tb.sv
module node_addr_filter_tb;
  localparam int W = 8;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         cfg_we_addr = 1'b0;
  logic         cfg_we_mask = 1'b0;
  logic [W-1:0] cfg_wdata = '0;
  logic         mp_en = 1'b0;
  logic         frm_done = 1'b0;
  logic         frm_bit9 = 1'b0;
  logic [W-1:0] frm_byte = '0;
  logic         sel_o;

  int n_chk = 0;
  int n_bad = 0;

  always #2.5 clk = ~clk;  // 200 MHz

  node_addr_filter #(.W(W)) u_dut (.*);

  // {addr, mask, byte, expected select}
  localparam int NV = 14;
  localparam logic [24:0] VEC [NV] = '{
    {8'hA4, 8'hFA, 8'hA0, 1'b1},
    {8'hA4, 8'hFA, 8'hA3, 1'b0},
    {8'hA4, 8'hFA, 8'hA1, 1'b1},
    {8'hA4, 8'hFA, 8'hFF, 1'b1},
    {8'hA4, 8'hFA, 8'hFE, 1'b1},
    {8'hA4, 8'hFA, 8'hFC, 1'b0},
    {8'hA7, 8'hF9, 8'hA3, 1'b1},
    {8'hA7, 8'hF9, 8'hA5, 1'b1},
    {8'hA7, 8'hF9, 8'hA0, 1'b0},
    {8'hA7, 8'hF9, 8'hFF, 1'b1},
    {8'hA7, 8'hF9, 8'hFE, 1'b0},
    {8'h00, 8'h00, 8'h5A, 1'b1},
    {8'hFF, 8'hFF, 8'hFF, 1'b1},
    {8'hFF, 8'hFF, 8'h7F, 1'b0}
  };

  task automatic check(input string req, input logic act, input logic exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: sel_o=%0b expected %0b", req, act, exp);
    end
  endtask

  task automatic wr(input logic which_mask, input logic [W-1:0] d);
    @(negedge clk);
    cfg_we_addr = ~which_mask;
    cfg_we_mask = which_mask;
    cfg_wdata   = d;
    @(negedge clk);
    cfg_we_addr = 1'b0;
    cfg_we_mask = 1'b0;
  endtask

  // One-cycle frame; sel_o sampled at the following falling edge.
  task automatic frame(input logic b9, input logic [W-1:0] b);
    @(negedge clk);
    frm_done = 1'b1;
    frm_bit9 = b9;
    frm_byte = b;
    @(negedge clk);
    frm_done = 1'b0;
  endtask

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog: run did not end, expected completion");
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 reset select", sel_o, 1'b1);
    mp_en = 1'b1;
    @(negedge clk);
    check("R1 reset select mp on", sel_o, 1'b1);
    frame(1'b1, 8'h3C);
    check("R1 open after reset", sel_o, 1'b1);

    for (int i = 0; i < NV; i++) begin
      wr(1'b0, VEC[i][24:17]);  // R2
      wr(1'b1, VEC[i][16:9]);   // R3
      frame(1'b1, VEC[i][8:1]);
      check("R4/R5/R6 vector", sel_o, VEC[i][0]);
    end

    // R7: a miss then a hit, each visible right after the frame
    wr(1'b0, 8'hA4);
    wr(1'b1, 8'hFA);
    frame(1'b1, 8'hA3);
    check("R7 miss taken", sel_o, 1'b0);
    frame(1'b1, 8'hA0);
    check("R7 hit taken", sel_o, 1'b1);

    // R8: data frames and idle cycles keep the result
    frame(1'b1, 8'hA3);
    frame(1'b0, 8'hA0);
    check("R8 data frame ignored", sel_o, 1'b0);
    repeat (4) @(negedge clk);
    check("R8 idle hold", sel_o, 1'b0);

    // R9: pass-through, no update while disabled
    mp_en = 1'b0;
    @(negedge clk);
    check("R9 pass-through", sel_o, 1'b1);
    frame(1'b1, 8'hA0);
    check("R9 pass-through after frame", sel_o, 1'b1);
    mp_en = 1'b1;
    @(negedge clk);
    check("R9 stored result returns", sel_o, 1'b0);

    // R10: mask write and address frame in the same cycle
    @(negedge clk);
    cfg_we_mask = 1'b1;
    cfg_wdata   = 8'h00;
    frm_done    = 1'b1;
    frm_bit9    = 1'b1;
    frm_byte    = 8'hA3;
    @(negedge clk);
    cfg_we_mask = 1'b0;
    frm_done    = 1'b0;
    check("R10 old mask used", sel_o, 1'b0);
    frame(1'b1, 8'hA3);
    check("R10 new mask next frame", sel_o, 1'b1);

    // R1: reset again restores open state
    rst_n = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    frame(1'b1, 8'h00);
    check("R1 registers cleared", sel_o, 1'b1);

    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule